// File: doc/BRIEF.md
# Serial PHY Management Controller

This block lets a host manage an Ethernet PHY over the two-wire management interface (MDC clock, bidirectional MDIO data) by writing to a small register port. A single 32-bit command word carries the target PHY address, the register number, a read/write opcode and, for writes, the 16 data bits. Accepting that word starts a complete clause-22 style frame: 32 preamble ones, a start pattern, the opcode, both addresses, a turnaround and 16 data bits, most significant bit first. The block generates MDC by dividing the system clock. It launches each MDIO bit after a falling MDC edge and samples returned bits on the rising edge.

The same command word reports status when read. A busy flag stays set while the serial engine runs. A read-valid flag rises when a read frame has finished, and the 16 returned bits then sit in the low half of that word. A second, 5-bit register holds the port's own PHY address. The host polls busy before it issues the next command. A command written while busy is dropped.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, MDC is low, MDIO is not driven, both register words read back as zero, and busy and read-valid are clear.
- R2: A write to the command word (reg_addr = 0) while idle sets busy (bit 28) from the next clock, and the frame starts.
- R3: A write to the command word while busy is ignored: the stored fields do not change and no additional frame is produced.
- R4: While busy, MDC is the system clock divided by CLK_DIV, with equal high and low halves. While idle, MDC is held low.
- R5: MDIO output changes only after a falling MDC edge, and returned data is sampled on rising MDC edges.
- R6: A write frame drives 64 bits, all with the output enabled: 32 ones, start 01, opcode 01, PHY address (5 bits), register number (5 bits), turnaround 10, then the 16 data bits, each field MSB first.
- R7: A read frame drives opcode 10 and releases MDIO (mdio_oe = 0) from the first turnaround bit (bit 46 of the frame) to the end. It captures 16 data bits MSB first at the last 16 rising MDC edges.
- R8: Busy clears on the falling MDC edge that follows the 64th bit. After a read, read-valid (bit 27) is set and the returned data reads back in bits [15:0]. After a write, read-valid stays clear.
- R9: Writing a new command clears read-valid from the next clock.
- R10: The PHY-address register (reg_addr = 1) keeps only bits [4:0] of a write and reads zero in bits [31:5].
- R11: The command word layout is: data in [15:0], PHY address in [20:16], register number in [25:21], opcode in bit 26 (1 = read, 0 = write), read-valid in bit 27, busy in bit 28.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 command/status word, 1 PHY-address register |
| reg_wen | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO value from the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
Several properties are checked on every clock. MDC stays low while idle, and MDIO holds still except after a falling MDC edge. No frame starts while busy. Busy clears only after the last bit's falling edge. Read-valid rises only at the end of a read frame and drops after a new command. The bench scenarios cover the things that need the whole frame. A scoreboard compares each bit on the wire, and its output-enable, against the expected frame at every rising MDC edge. It also checks the MDC period, the data a responder returns, a command dropped while busy, and the masking of the PHY-address register.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int TA_IDX     = 46;
  localparam int DATA_IDX   = 48;
  localparam int OP_BIT     = 26;
  localparam int RVALID_BIT = 27;
  localparam int BUSY_BIT   = 28;

  typedef struct packed {
    logic        op_rd;
    logic [4:0]  regnum;
    logic [4:0]  phy;
    logic [15:0] data;
  } mdio_cmd_t;

  function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.op_rd ? 2'b10 : 2'b01;
    ta = c.op_rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regnum, ta, c.data};
  endfunction
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
  parameter int CLK_DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_ev,
  output logic fall_ev
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          edge_ev;

  assign edge_ev = run && (cnt_q == CW'(HALF - 1));
  assign rise_ev = edge_ev && !mdc_q;
  assign fall_ev = edge_ev && mdc_q;
  assign mdc     = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (edge_ev) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  // R4: clock parked low whenever the engine is idle
  assert_mdc_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

  // R4: MDC only toggles while the engine runs
  assert_mdc_toggle_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc_q) |-> $past(run));
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  mdio_cmd_t   cmd,
  input  logic        rise_ev,
  input  logic        fall_ev,
  input  logic        mdio_i,
  output logic        busy,
  output logic        rvalid,
  output logic [15:0] rd_data,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic                  busy_q, busy_d;
  logic                  rvalid_q, rvalid_d;
  logic                  rd_op_q, rd_op_d;
  logic                  oe_q, oe_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [FRAME_BITS-1:0] sr_q, sr_d;
  logic [15:0]           rd_q, rd_d;
  logic [IDX_W:0]        idx_nxt;

  assign idx_nxt = {1'b0, idx_q} + 1'b1;

  always_comb begin
    busy_d   = busy_q;
    rvalid_d = rvalid_q;
    rd_op_d  = rd_op_q;
    oe_d     = oe_q;
    idx_d    = idx_q;
    sr_d     = sr_q;
    rd_d     = rd_q;
    if (start) begin
      busy_d   = 1'b1;
      rvalid_d = 1'b0;
      rd_op_d  = cmd.op_rd;
      oe_d     = 1'b1;
      idx_d    = '0;
      sr_d     = build_frame(cmd);
      rd_d     = '0;
    end else if (busy_q) begin
      if (rise_ev && rd_op_q && (idx_q >= IDX_W'(DATA_IDX)))
        rd_d = {rd_q[14:0], mdio_i};
      if (fall_ev) begin
        if (idx_q == IDX_W'(FRAME_BITS - 1)) begin
          busy_d   = 1'b0;
          rvalid_d = rd_op_q;
          oe_d     = 1'b0;
        end else begin
          idx_d = idx_nxt[IDX_W-1:0];
          sr_d  = {sr_q[FRAME_BITS-2:0], 1'b0};
          oe_d  = !(rd_op_q && (idx_nxt >= (IDX_W+1)'(TA_IDX)));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rvalid_q <= 1'b0;
      rd_op_q  <= 1'b0;
      oe_q     <= 1'b0;
      idx_q    <= '0;
      sr_q     <= '0;
      rd_q     <= '0;
    end else begin
      busy_q   <= busy_d;
      rvalid_q <= rvalid_d;
      rd_op_q  <= rd_op_d;
      oe_q     <= oe_d;
      idx_q    <= idx_d;
      sr_q     <= sr_d;
      rd_q     <= rd_d;
    end
  end

  assign busy    = busy_q;
  assign rvalid  = rvalid_q;
  assign rd_data = rd_q;
  assign mdio_o  = sr_q[FRAME_BITS-1];
  assign mdio_oe = oe_q;

  // R3: a frame can only be launched from idle
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q);

  // R5: pin value holds except right after a falling MDC edge
  assert_mdio_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && !$past(fall_ev)) |-> $stable(sr_q[FRAME_BITS-1]));

  // R8: busy ends only at the falling edge after the last bit
  assert_busy_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(fall_ev) && ($past(idx_q) == IDX_W'(FRAME_BITS - 1))));

  // R8: read-valid rises only when a read frame completes
  assert_rvalid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid_q) |-> ($fell(busy_q) && $past(rd_op_q)));

  // R9: a new command drops read-valid
  assert_rvalid_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !rvalid_q);
endmodule

// File: rtl/mdio_host_regs.sv
module mdio_host_regs
  import mdio_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  input  logic        busy,
  input  logic        rvalid,
  input  logic [15:0] rd_data,
  output logic        start,
  output mdio_cmd_t   new_cmd,
  output logic [31:0] reg_rdata
);
  mdio_cmd_t  cmd_q, cmd_d;
  logic [4:0] own_q, own_d;
  logic [15:0] data_view;

  assign new_cmd = mdio_cmd_t'(reg_wdata[OP_BIT:0]);
  assign start   = reg_wen && !reg_addr && !busy;

  always_comb begin
    cmd_d = start ? new_cmd : cmd_q;
    own_d = (reg_wen && reg_addr) ? reg_wdata[4:0] : own_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      own_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      own_q <= own_d;
    end
  end

  assign data_view = cmd_q.op_rd ? rd_data : cmd_q.data;

  always_comb begin
    if (reg_addr)
      reg_rdata = {27'd0, own_q};
    else
      reg_rdata = {3'd0, busy, rvalid, cmd_q.op_rd, cmd_q.regnum, cmd_q.phy, data_view};
  end

  // R3: stored command fields stay put while the engine is busy
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_q));

  // R10: own-address register takes the low five bits written
  assert_own_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr) |=> (own_q == $past(reg_wdata[4:0])));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int CLK_DIV = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_addr,
  input  logic        reg_wen,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  logic        start;
  mdio_cmd_t   new_cmd;
  logic        busy;
  logic        rvalid;
  logic [15:0] rd_data;
  logic        rise_ev;
  logic        fall_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_host_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .reg_addr  (reg_addr),
    .reg_wen   (reg_wen),
    .reg_wdata (reg_wdata),
    .busy      (busy),
    .rvalid    (rvalid),
    .rd_data   (rd_data),
    .start     (start),
    .new_cmd   (new_cmd),
    .reg_rdata (reg_rdata)
  );

  mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (busy),
    .mdc     (mdc),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  mdio_frame_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .cmd     (new_cmd),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .rvalid  (rvalid),
    .rd_data (rd_data),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe)
  );
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  localparam int DIV = 16;

  logic        clk;
  logic        rst_n;
  logic        reg_addr;
  logic        reg_wen;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_i;
  logic        mdio_o;
  logic        mdio_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  logic [1:0] exp_q[$];
  int          rise_idx = 0;
  int          last_rise = 0;
  logic        mdc_prev = 1'b0;
  logic        resp_read = 1'b0;
  logic [15:0] resp_val = '0;
  bit          mon_on = 0;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard and PHY responder
  always @(negedge clk) begin
    if (mon_on && mdc && !mdc_prev) begin
      logic [1:0] e;
      if (rise_idx > 0)
        chk((cyc - last_rise) == DIV, "R4 mdc period", cyc - last_rise, DIV);
      last_rise = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R3 unexpected frame bit", 32'd1, 32'd0);
      end else begin
        e = exp_q.pop_front();
        chk(mdio_oe == e[1], "R7 output enable", {31'd0, mdio_oe}, {31'd0, e[1]});
        if (e[1]) chk(mdio_o == e[0], "R6 frame bit", {31'd0, mdio_o}, {31'd0, e[0]});
      end
      if (resp_read && rise_idx >= 47 && rise_idx < 63) mdio_i = resp_val[62 - rise_idx];
      else mdio_i = 1'b1;
      rise_idx++;
    end
    mdc_prev = mdc;
  end

  task automatic push_frame(input bit rd, input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
    logic [63:0] f;
    f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
    for (int i = 0; i < 64; i++) begin
      logic oe;
      oe = !(rd && i >= 46);
      exp_q.push_back({oe, f[63 - i]});
    end
  endtask

  task automatic wr_reg(input logic a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0; reg_addr = 1'b0;
    #1;
  endtask

  task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] d, input logic [15:0] resp);
    resp_read = rd; resp_val = resp; rise_idx = 0;
    push_frame(rd, phy, rg, d);
    wr_reg(1'b0, {5'd0, rd, rg, phy, d});
    chk(reg_rdata[28] == 1'b1, "R2 busy after write", reg_rdata, 32'h1000_0000);
    chk(reg_rdata[26:16] == {rd, rg, phy}, "R11 field readback", {21'd0, reg_rdata[26:16]}, {21'd0, rd, rg, phy});
    chk(reg_rdata[27] == 1'b0, "R9 read-valid cleared", reg_rdata, 32'd0);
  endtask

  task automatic wait_done(input bit rd, input logic [15:0] resp);
    reg_addr = 1'b0; #1;
    while (reg_rdata[28]) begin @(negedge clk); #1; end
    chk(exp_q.size() == 0, "R8 frame length", exp_q.size(), 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R4 idle pins", {30'd0, mdc, mdio_oe}, 0);
    chk(reg_rdata[27] == rd, "R8 read-valid", {31'd0, reg_rdata[27]}, {31'd0, rd});
    if (rd) chk(reg_rdata[15:0] == resp, "R8 read data", {16'd0, reg_rdata[15:0]}, {16'd0, resp});
  endtask

  initial begin
    rst_n = 1'b0; reg_addr = 1'b0; reg_wen = 1'b0; reg_wdata = '0; mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(reg_rdata == 32'd0, "R1 command word reset", reg_rdata, 0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R1 pins reset", {30'd0, mdc, mdio_oe}, 0);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 32'd0, "R1 own address reset", reg_rdata, 0);
    reg_addr = 1'b0;
    mon_on = 1;

    // R10 masking
    wr_reg(1'b1, 32'hFFFF_FFE5);
    reg_addr = 1'b1; #1;
    chk(reg_rdata == 32'h0000_0005, "R10 own address", reg_rdata, 32'h5);
    reg_addr = 1'b0; #1;
    chk(reg_rdata[28] == 1'b0, "R10 no frame from own address write", reg_rdata, 0);

    // R6 write frame
    issue(1'b0, 5'h11, 5'h0A, 16'hA5C3, 16'h0);
    wait_done(1'b0, 16'h0);

    // R7 read frame
    issue(1'b1, 5'h1F, 5'h01, 16'h0, 16'h796D);
    wait_done(1'b1, 16'h796D);

    // R9 new write clears read-valid (checked inside issue), then R3 drop while busy
    issue(1'b0, 5'h00, 5'h1F, 16'hFFFF, 16'h0);
    repeat (200) @(negedge clk);
    reg_addr = 1'b0; reg_wdata = {5'd0, 1'b1, 5'h03, 5'h04, 16'h1234}; reg_wen = 1'b1;
    @(negedge clk); reg_wen = 1'b0; #1;
    chk(reg_rdata[26:0] == {1'b0, 5'h1F, 5'h00, 16'hFFFF}, "R3 fields kept while busy",
        {5'd0, reg_rdata[26:0]}, {5'd0, 1'b0, 5'h1F, 5'h00, 16'hFFFF});
    wait_done(1'b0, 16'h0);
    repeat (3 * DIV) @(negedge clk); #1;
    chk(reg_rdata[28] == 1'b0, "R3 dropped command not started", reg_rdata, 0);

    // R8 read with alternating data
    issue(1'b1, 5'h05, 5'h15, 16'hBEEF, 16'h8001);
    wait_done(1'b1, 16'h8001);
    issue(1'b1, 5'h0E, 5'h02, 16'h0, 16'h0000);
    wait_done(1'b1, 16'h0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule